// File: doc/BRIEF.md
# Flash Status Word Generator

This block forms the byte that a flash device returns on a bus read while an embedded program or erase is running, or while an erase is held in suspension. The controller that owns the operation tells the block which operation is active, bit 7 of the value being programmed, which blocks are being erased, which of them failed, and whether the erase has begun or is suspended. The block then builds the polling, toggle, error, erase-timer and alternate-toggle fields of the status byte.

Two toggle flip-flops advance on read strobes. The main toggle advances on every status read at any address. The alternate toggle advances only when the read address falls inside a block that is being erased. After an erase failure, it advances only when the read address falls inside a block that failed. During suspension, reads outside the erasing blocks return the array byte supplied by the caller. When no operation is active, every read returns the array byte.

The output is combinational from the inputs and the internal flops. A read strobe that is sampled on a clock edge advances the toggles, so the next read returns the new value.

Top module: `flash_status_gen`

## Requirements
- R1: Bit 7 of the status byte is the inverse of `progBit7` while a program is active (`opKind`=1). It is 0 while a block erase (`opKind`=2) or chip erase (`opKind`=3) is active, unless R2 applies.
- R2: While a block erase is suspended (`suspended`=1, `opKind`=2), a read inside an erasing block returns bit 7 = 1. In that state, bit 6 does not change on any read.
- R3: Bit 6 is the main toggle. It inverts after each sampled `rdStb` while an operation is active and not suspended, whatever the read address.
- R4: Bit 5 is set in the cycle after `failSet` is sampled. It stays set until `errClr` is sampled while `failSet` is low.
- R5: Bit 3 reads 1 during a chip erase. During a block erase it follows `eraseStarted`. During a program it reads 0.
- R6: Bit 2 shows the alternate toggle during either erase and reads 0 during a program. The alternate toggle inverts on a sampled `rdStb` only when the read block is erasing (during chip erase every block counts as erasing), whether the erase is running or suspended. Other reads leave it unchanged.
- R7: While bit 5 is set during an erase, the alternate toggle advances only for reads whose block has its `failMap` bit set.
- R8: When no operation is active (`opKind`=0), or when a suspended block erase is read outside its erasing blocks, `dataOut` equals `arrayData` and `statusSel` is 0. In every other case `statusSel` is 1.
- R9: A sampled `opStart` clears both toggles, and this takes priority over a read sampled in the same cycle.
- R10: Bits 4, 1 and 0 of the status byte read 0.
- R11: Without a sampled `rdStb`, neither toggle changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opStart | input | 1 | Pulse marking the start of a new operation |
| opKind | input | 2 | 0 idle, 1 program, 2 block erase, 3 chip erase |
| progBit7 | input | 1 | Bit 7 of the value being programmed |
| eraseMap | input | NUM_BLOCKS | One bit per block that is being erased |
| failMap | input | NUM_BLOCKS | One bit per block that failed to erase |
| readBlk | input | BLK_W | Block index of the current read address |
| eraseStarted | input | 1 | Block erase has left its selection window |
| suspended | input | 1 | Block erase is suspended |
| failSet | input | 1 | Pulse reporting an operation failure |
| errClr | input | 1 | Pulse from a read/reset command |
| rdStb | input | 1 | A bus read takes place in this cycle |
| arrayData | input | 8 | Array byte at the read address |
| dataOut | output | 8 | Byte returned to the bus |
| statusSel | output | 1 | 1 when dataOut carries the status byte |

## Verification
The embedded assertions check, on every cycle, how the flops evolve: the main toggle inverts after each qualifying read and holds through suspension, both toggles hold when there is no strobe, and a start pulse clears both toggles. They also check that the error bit stays set until it is cleared and that the unused bits of the status byte stay at zero. The bench scenarios are needed to show the contents of the output byte. These contents are the polling value under each operation, the erase-timer bit, the choice between array and status during suspension, and the effect of the fail map on which block addresses move the alternate toggle. The bench checks these against a model across random operation mixes and directed sequences.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  localparam int WORD_W   = 8;
  localparam int POS_POLL = 7;
  localparam int POS_TGL  = 6;
  localparam int POS_ERR  = 5;
  localparam int POS_TMR  = 3;
  localparam int POS_ALT  = 2;

  typedef enum logic [1:0] {
    OP_IDLE      = 2'd0,
    OP_PROG      = 2'd1,
    OP_BLKERASE  = 2'd2,
    OP_CHIPERASE = 2'd3
  } opKind_e;

  // strobes and field selects from control to datapath
  typedef struct packed {
    logic tglAAdv;
    logic tglBAdv;
    logic tglClr;
    logic errSet;
    logic errClr;
    logic selArray;
    logic pollOne;
    logic pollProg;
    logic timerBit;
    logic altShow;
  } srStrobes_t;

endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int NUM_BLOCKS = 19,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opStart,
  input  logic [1:0]            opKind,
  input  logic [NUM_BLOCKS-1:0] eraseMap,
  input  logic [NUM_BLOCKS-1:0] failMap,
  input  logic [BLK_W-1:0]      readBlk,
  input  logic                  eraseStarted,
  input  logic                  suspended,
  input  logic                  failSet,
  input  logic                  errClr,
  input  logic                  rdStb,
  input  logic                  errQ,
  output srStrobes_t            strobes
);

  opKind_e               opNow;
  logic [NUM_BLOCKS-1:0] blkHit;
  logic                  active;
  logic                  isErase;
  logic                  suspEff;
  logic                  inErasing;
  logic                  inFailed;

  // one-hot decode of the read block; out-of-range indices hit nothing
  genvar gi;
  generate
    for (gi = 0; gi < NUM_BLOCKS; gi++) begin : g_hit
      assign blkHit[gi] = (readBlk == BLK_W'(gi));
    end
  endgenerate

  always_comb begin
    opNow     = opKind_e'(opKind);
    active    = (opNow != OP_IDLE);
    isErase   = (opNow == OP_BLKERASE) || (opNow == OP_CHIPERASE);
    suspEff   = suspended && (opNow == OP_BLKERASE);
    inErasing = isErase && ((opNow == OP_CHIPERASE) || (|(blkHit & eraseMap)));
    inFailed  = |(blkHit & failMap);

    strobes          = '0;
    strobes.selArray = !active || (suspEff && !inErasing);
    strobes.tglAAdv  = rdStb && active && !suspEff;
    strobes.tglBAdv  = rdStb && inErasing && (!errQ || inFailed);
    strobes.tglClr   = opStart;
    strobes.errSet   = failSet;
    strobes.errClr   = errClr;
    strobes.pollOne  = suspEff && inErasing;
    strobes.pollProg = (opNow == OP_PROG);
    strobes.timerBit = (opNow == OP_CHIPERASE) ||
                       ((opNow == OP_BLKERASE) && eraseStarted);
    strobes.altShow  = isErase;
  end

  AST_SUSP_NO_MAIN_ADV: assert property (@(posedge clk) disable iff (!rstN)
    (suspended && opKind == 2'd2) |-> !strobes.tglAAdv) else $error("main toggle advanced in suspend"); // R2

  AST_ALT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |-> !strobes.tglAAdv && !strobes.tglBAdv) else $error("toggle advance without read"); // R11

endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  srStrobes_t        strobes,
  input  logic              progBit7,
  input  logic [WORD_W-1:0] arrayData,
  output logic [WORD_W-1:0] dataOut,
  output logic              statusSel,
  output logic              errQ,
  output logic              tglAQ,
  output logic              tglBQ
);

  logic [WORD_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tglAQ <= 1'b0;
      tglBQ <= 1'b0;
    end else if (strobes.tglClr) begin
      tglAQ <= 1'b0;
      tglBQ <= 1'b0;
    end else begin
      if (strobes.tglAAdv) tglAQ <= !tglAQ;
      if (strobes.tglBAdv) tglBQ <= !tglBQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               errQ <= 1'b0;
    else if (strobes.errSet) errQ <= 1'b1;
    else if (strobes.errClr) errQ <= 1'b0;
  end

  always_comb begin
    statusWord           = '0;
    statusWord[POS_POLL] = strobes.pollOne ? 1'b1 :
                           (strobes.pollProg ? !progBit7 : 1'b0);
    statusWord[POS_TGL]  = tglAQ;
    statusWord[POS_ERR]  = errQ;
    statusWord[POS_TMR]  = strobes.timerBit;
    statusWord[POS_ALT]  = strobes.altShow && tglBQ;
    dataOut              = strobes.selArray ? arrayData : statusWord;
    statusSel            = !strobes.selArray;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !strobes.errClr) |=> errQ) else $error("error bit dropped"); // R4

  AST_CLR_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tglClr |=> (!tglAQ && !tglBQ)) else $error("toggles not cleared"); // R9

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusSel |-> (dataOut[4] == 1'b0 && dataOut[1:0] == 2'b00)) else $error("spare bits set"); // R10

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int NUM_BLOCKS = 19,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opStart,
  input  logic [1:0]            opKind,
  input  logic                  progBit7,
  input  logic [NUM_BLOCKS-1:0] eraseMap,
  input  logic [NUM_BLOCKS-1:0] failMap,
  input  logic [BLK_W-1:0]      readBlk,
  input  logic                  eraseStarted,
  input  logic                  suspended,
  input  logic                  failSet,
  input  logic                  errClr,
  input  logic                  rdStb,
  input  logic [7:0]            arrayData,
  output logic [7:0]            dataOut,
  output logic                  statusSel
);

  srStrobes_t strobes;
  logic       errQ;
  logic       tglAQ;
  logic       tglBQ;

  flash_status_ctrl #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opKind(opKind),
    .eraseMap(eraseMap), .failMap(failMap), .readBlk(readBlk),
    .eraseStarted(eraseStarted), .suspended(suspended), .failSet(failSet),
    .errClr(errClr), .rdStb(rdStb), .errQ(errQ), .strobes(strobes)
  );

  flash_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .progBit7(progBit7),
    .arrayData(arrayData), .dataOut(dataOut), .statusSel(statusSel),
    .errQ(errQ), .tglAQ(tglAQ), .tglBQ(tglBQ)
  );

  AST_MAIN_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && opKind != 2'd0 && !(suspended && opKind == 2'd2) && !opStart)
      |=> (tglAQ != $past(tglAQ))) else $error("main toggle did not flip"); // R3

  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (suspended && opKind == 2'd2 && !opStart) |=> $stable(tglAQ)) else $error("main toggle moved in suspend"); // R2

  AST_NO_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStb && !opStart) |=> ($stable(tglAQ) && $stable(tglBQ))) else $error("toggle moved without read"); // R11

  AST_PROG_ALT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == 2'd1 && !opStart) |=> $stable(tglBQ)) else $error("alt toggle moved in program"); // R6

endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;

  localparam int NB = 19;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opStart = 1'b0;
  logic [1:0]    opKind = 2'd0;
  logic          progBit7 = 1'b0;
  logic [NB-1:0] eraseMap = '0;
  logic [NB-1:0] failMap = '0;
  logic [BW-1:0] readBlk = '0;
  logic          eraseStarted = 1'b0;
  logic          suspended = 1'b0;
  logic          failSet = 1'b0;
  logic          errClr = 1'b0;
  logic          rdStb = 1'b0;
  logic [7:0]    arrayData = 8'h00;
  logic [7:0]    dataOut;
  logic          statusSel;

  int  nCmp = 0;
  int  nBad = 0;
  bit  finished = 0;
  logic mA = 0, mB = 0, mErr = 0;

  always #5 clk = ~clk;

  flash_status_gen #(.NUM_BLOCKS(NB), .BLK_W(BW)) u0 (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opKind(opKind),
    .progBit7(progBit7), .eraseMap(eraseMap), .failMap(failMap),
    .readBlk(readBlk), .eraseStarted(eraseStarted), .suspended(suspended),
    .failSet(failSet), .errClr(errClr), .rdStb(rdStb),
    .arrayData(arrayData), .dataOut(dataOut), .statusSel(statusSel)
  );

  function automatic bit inBlk(input logic [NB-1:0] m);
    return (int'(readBlk) < NB) ? m[readBlk] : 1'b0;
  endfunction
  function automatic bit mSusp();
    return suspended && opKind == 2'd2;
  endfunction
  function automatic bit mInside();
    return opKind == 2'd3 || (opKind == 2'd2 && inBlk(eraseMap));
  endfunction
  function automatic bit mArray();
    return opKind == 2'd0 || (mSusp() && !mInside());
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic checkNow();
    logic [7:0] e;
    if (mArray()) begin
      chk(dataOut == arrayData && !statusSel, "R8", dataOut, arrayData);
    end else begin
      e = '0;
      e[7] = (mSusp() && mInside()) ? 1'b1 : (opKind == 2'd1 ? !progBit7 : 1'b0);
      e[6] = mA;
      e[5] = mErr;
      e[3] = (opKind == 2'd3) || (opKind == 2'd2 && eraseStarted);
      e[2] = opKind[1] && mB;
      chk(statusSel, "R8", {7'd0, statusSel}, 8'd1);
      chk(dataOut[7] == e[7], (mSusp() && mInside()) ? "R2" : "R1", dataOut, e);
      chk(dataOut[6] == e[6], "R3", dataOut, e);
      chk(dataOut[5] == e[5], "R4", dataOut, e);
      chk(dataOut[3] == e[3], "R5", dataOut, e);
      chk(dataOut[2] == e[2], (mErr && opKind[1]) ? "R7" : "R6", dataOut, e);
      chk(dataOut[4] == 1'b0 && dataOut[1:0] == 2'b00, "R10", dataOut, e);
    end
  endtask

  // check at the falling edge, then advance the model with the rising edge
  task automatic cyc();
    bit advA, advB;
    @(negedge clk);
    checkNow();
    @(posedge clk);
    advA = rdStb && opKind != 2'd0 && !mSusp();
    advB = rdStb && mInside() && (!mErr || inBlk(failMap));
    if (opStart) begin
      mA = 0; mB = 0;
    end else begin
      if (advA) mA = !mA;
      if (advB) mB = !mB;
    end
    if (failSet) mErr = 1;
    else if (errClr) mErr = 0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state: idle returns array byte (R8)
    arrayData = 8'h5A; rdStb = 1; cyc();
    // program, bit7 inverse of target (R1), toggling reads (R3)
    opKind = 2'd1; progBit7 = 1; opStart = 1; rdStb = 0; cyc();
    opStart = 0; rdStb = 1;
    repeat (3) cyc();
    progBit7 = 0; cyc();
    // start pulse with read in same cycle clears toggles (R9)
    opStart = 1; cyc(); opStart = 0; rdStb = 0;
    @(negedge clk); chk(dataOut[6] == 1'b0, "R9", dataOut, 8'h00); @(posedge clk); #1;
    // no strobe: hold (R11)
    rdStb = 1; cyc(); rdStb = 0;
    @(negedge clk); held = dataOut; @(posedge clk); #1;
    @(negedge clk); chk(dataOut[6] == held[6], "R11", dataOut, held); @(posedge clk); #1;
    // block erase: open window then started (R5), alt toggle only in erasing blocks (R6)
    opKind = 2'd2; opStart = 1; eraseMap = '0; eraseMap[2] = 1; eraseMap[5] = 1; cyc();
    opStart = 0; rdStb = 1; readBlk = 5'd2; cyc(); cyc();
    readBlk = 5'd7; cyc(); cyc();
    eraseStarted = 1; readBlk = 5'd5; cyc();
    // suspension: inside returns poll 1 (R2), outside returns array (R8)
    suspended = 1; cyc(); cyc();
    readBlk = 5'd9; arrayData = 8'hC3; cyc();
    suspended = 0;
    // error: only failed block moves alt toggle (R7), error sticky (R4)
    failMap = '0; failMap[5] = 1; failSet = 1; readBlk = 5'd2; cyc();
    failSet = 0; repeat (3) cyc();
    readBlk = 5'd5; repeat (3) cyc();
    errClr = 1; cyc(); errClr = 0; cyc();
    // chip erase: every block counts (R5, R6)
    opKind = 2'd3; opStart = 1; cyc(); opStart = 0; readBlk = 5'd20; repeat (3) cyc();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      opStart = ($urandom_range(15) == 0);
      if (opStart) begin
        opKind = 2'($urandom_range(3));
        eraseMap = NB'($urandom);
        failMap = NB'($urandom);
      end
      progBit7 = 1'($urandom);
      readBlk = BW'($urandom_range(23));
      eraseStarted = 1'($urandom);
      suspended = ($urandom_range(3) == 0);
      failSet = ($urandom_range(39) == 0);
      errClr = ($urandom_range(29) == 0);
      rdStb = 1'($urandom);
      arrayData = 8'($urandom);
      cyc();
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule